// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Change Interrupt

This block is an eight-bit general-purpose port placed behind a serial slave front end. Each pin has an output latch. A latch holding 0 drives the pin low. A latch holding 1 releases the pin to a weak high, so an outside source can pull it either way and the pin then serves as an input. The pin levels pass through a synchronizer, and the synchronized value is returned as the read byte.

The block compares the released pins with a reference copy of the pin levels. This reference is taken each time the interrupt is reset. When a released pin differs from the reference, the difference is latched on the next SCL rising strobe, and the active-low interrupt output is then asserted. The interrupt is reset in three ways:
- by the acknowledge of a port read, on the SCL rising strobe;
- by the acknowledge of a port write, on the SCL falling strobe;
- by every changed pin returning to its reference level.

The front end supplies single-cycle SCL edge strobes, an acknowledge window flag, and select flags that say whether the current access is a read or a write of this port.

Top module: `qbp_port`

## Requirements
- R1: While reset is held and in the first cycle after it, every latch holds 1. No drive-low enable is set, and `int_n` is 1.
- R2: A `wr_stb` pulse loads `wr_data` into the latches at that clock edge. From the next cycle on, `pin_pull_low[i]` is the inverse of latch bit i, where 1 means the pin is driven low.
- R3: `rd_data` equals `pin_in` delayed by `SYNC_STAGES` clock edges.
- R4: A released pin whose synchronized level differs from the reference does not assert the interrupt on its own. The first `scl_rise` strobe after the difference appears sets `int_n` to 0 from the next cycle.
- R5: A pin whose latch holds 0 never contributes to the interrupt.
- R6: An `scl_rise` strobe while `ack_bit` and `rd_sel` are both 1 resets the interrupt. `int_n` is 1 in the next cycle, and the reference takes the current synchronized pins.
- R7: An `scl_fall` strobe while `ack_bit` and `wr_sel` are both 1 resets the interrupt and takes a new reference. An `scl_rise` strobe during a write acknowledge does not reset it.
- R8: When every differing released pin returns to its reference level, `int_n` goes back to 1. A later difference needs a new `scl_rise` strobe before it is reported.
- R9: SCL strobes during an acknowledge window are ignored for the reset when `rd_sel` and `wr_sel` are both 0. An access to another device leaves `int_n` unchanged.
- R10: When a reset edge and a capturing `scl_rise` fall in the same cycle, the reset wins. A pin change already synchronized in that cycle goes into the new reference and is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_rise | input | 1 | One-cycle strobe for an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe for an SCL falling edge |
| ack_bit | input | 1 | High during the acknowledge bit of an access |
| rd_sel | input | 1 | The current access is a read of this port |
| wr_sel | input | 1 | The current access is a write of this port |
| wr_stb | input | 1 | Loads `wr_data` into the output latches |
| wr_data | input | W | Byte for the output latches |
| pin_in | input | W | Sensed pin levels |
| pin_pull_low | output | W | Per-pin drive-low enable |
| rd_data | output | W | Synchronized pin levels |
| int_n | output | 1 | Active-low interrupt, open-drain style |

## Verification
A pin change that has just reached the synchronizer output can meet a read-acknowledge reset edge that is also an SCL rising strobe. That one edge then both captures the change and resets the interrupt. The bench times the pin change so that the synchronized value lands exactly one cycle before that strobe. It then expects `int_n` to stay high across the edge and across a later plain `scl_rise`, which shows the change went into the reference. Restoring the pin afterwards must raise the interrupt again, which confirms the reference really moved.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic ack;
    logic rd_sel;
    logic wr_sel;
  } qbp_bus_t;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '1;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] lat,
  output logic [W-1:0] pull_low
);
  logic [W-1:0] lat_d, lat_q;

  always_comb begin
    lat_d = lat_q;
    if (load) lat_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '1;
    else        lat_q <= lat_d;
  end

  assign lat      = lat_q;
  assign pull_low = ~lat_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pull_low == ~$past(din)));
endmodule

// File: rtl/qbp_irq.sv
module qbp_irq
  import qbp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  qbp_bus_t     bus,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] in_mask,
  output logic         int_n
);
  logic [W-1:0] ref_d, ref_q, diff;
  logic         pend_d, pend_q;
  logic         rd_clr, wr_clr, clr, any_diff;

  assign diff     = (pins ^ ref_q) & in_mask;
  assign any_diff = |diff;
  assign rd_clr   = bus.scl_rise & bus.ack & bus.rd_sel;
  assign wr_clr   = bus.scl_fall & bus.ack & bus.wr_sel;
  assign clr      = rd_clr | wr_clr;

  always_comb begin
    ref_d  = ref_q;
    pend_d = pend_q;
    if (clr) begin
      ref_d  = pins;
      pend_d = 1'b0;
    end else if (!any_diff) begin
      pend_d = 1'b0;
    end else if (bus.scl_rise) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      pend_q <= pend_d;
    end
  end

  assign int_n = ~(pend_q & any_diff);

  assert_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(bus.scl_rise));
  assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mask == '0) |-> int_n);
  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus.scl_rise && bus.ack && bus.rd_sel) |=> int_n);
  assert_wr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus.scl_fall && bus.ack && bus.wr_sel) |=> int_n);
endmodule

// File: rtl/qbp_port.sv
module qbp_port
  import qbp_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         ack_bit,
  input  logic         rd_sel,
  input  logic         wr_sel,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_pull_low,
  output logic [W-1:0] rd_data,
  output logic         int_n
);
  logic [1:0]   rst_sync_q;
  logic         rst_n_i;
  logic [W-1:0] lat, pins_s;
  qbp_bus_t     bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign bus = '{scl_rise: scl_rise, scl_fall: scl_fall, ack: ack_bit,
                 rd_sel: rd_sel, wr_sel: wr_sel};

  qbp_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n_i), .load(wr_stb), .din(wr_data),
    .lat(lat), .pull_low(pin_pull_low)
  );

  qbp_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d(pin_in), .q(pins_s)
  );

  qbp_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n_i), .bus(bus), .pins(pins_s),
    .in_mask(lat), .int_n(int_n)
  );

  assign rd_data = pins_s;
endmodule

// File: tb/sim_qbp_port.sv
module sim_qbp_port;
  localparam int W = 8;

  typedef struct {
    string      req;
    int         kind;
    logic [7:0] exp;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic scl_rise = 0, scl_fall = 0, ack_bit = 0, rd_sel = 0, wr_sel = 0, wr_stb = 0;
  logic [W-1:0] wr_data = '0, ext = '1, lat_m = '1;
  logic [W-1:0] pin_in, pin_pull_low, rd_data;
  logic int_n;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign pin_in = ext & lat_m;

  qbp_port #(.W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ack_bit(ack_bit), .rd_sel(rd_sel), .wr_sel(wr_sel), .wr_stb(wr_stb),
    .wr_data(wr_data), .pin_in(pin_in), .pin_pull_low(pin_pull_low),
    .rd_data(rd_data), .int_n(int_n)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? {7'd0, int_n} : (it.kind == 1) ? pin_pull_low : rd_data;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic expect_int(string r, logic v);
    item_t it; it.req = r; it.kind = 0; it.exp = {7'd0, v}; q.push_back(it);
  endtask
  task automatic expect_oe(string r, logic [7:0] v);
    item_t it; it.req = r; it.kind = 1; it.exp = v; q.push_back(it);
  endtask
  task automatic expect_rd(string r, logic [7:0] v);
    item_t it; it.req = r; it.kind = 2; it.exp = v; q.push_back(it);
  endtask

  task automatic settle; step(1); @(negedge clk); #1; endtask

  task automatic wr_port(logic [7:0] v);
    wr_data = v; wr_stb = 1; step(1); wr_stb = 0; lat_m = v;
  endtask

  task automatic pulse(logic r, logic f, logic a, logic rs, logic ws);
    scl_rise = r; scl_fall = f; ack_bit = a; rd_sel = rs; wr_sel = ws;
    step(1);
    scl_rise = 0; scl_fall = 0; ack_bit = 0; rd_sel = 0; wr_sel = 0;
  endtask

  initial begin
    step(3);
    expect_int("R1", 1); expect_oe("R1", 8'h00); settle;
    rst_n = 1; step(3);
    expect_int("R1", 1); expect_oe("R1", 8'h00); expect_rd("R1", 8'hFF); settle;

    // R2/R3 drive the upper nibble low
    wr_port(8'h0F);
    expect_oe("R2", 8'hF0); settle;
    step(2);
    expect_rd("R3", 8'h0F); expect_int("R5", 1); settle;
    wr_port(8'hFF); step(3);
    expect_rd("R3", 8'hFF); settle;

    // R4 change needs an scl_rise
    ext[3] = 0; step(4);
    expect_int("R4", 1); settle;
    pulse(1, 0, 0, 0, 0);
    expect_int("R4", 0); settle;

    // R9 other-device acknowledge
    pulse(1, 0, 1, 0, 0); pulse(0, 1, 1, 0, 0);
    expect_int("R9", 0); settle;

    // R7 rising edge during write ack does not clear; falling edge does
    pulse(1, 0, 1, 0, 1);
    expect_int("R7", 0); settle;
    pulse(0, 1, 1, 0, 1);
    expect_int("R7", 1); settle;

    // R6 read ack clear
    ext[3] = 1; step(4); pulse(1, 0, 0, 0, 0);
    expect_int("R6", 0); settle;
    pulse(1, 0, 1, 1, 0);
    expect_int("R6", 1); settle;
    pulse(1, 0, 0, 0, 0);
    expect_int("R6", 1); settle;

    // R8 return to reference
    ext[0] = 0; step(4); pulse(1, 0, 0, 0, 0);
    expect_int("R8", 0); settle;
    ext[0] = 1; step(4);
    expect_int("R8", 1); settle;
    ext[0] = 0; step(4);
    expect_int("R8", 1); settle;
    pulse(1, 0, 0, 0, 0);
    expect_int("R8", 0); settle;
    ext[0] = 1; step(4);
    expect_int("R8", 1); settle;

    // R5 output pin low is not an input change
    wr_port(8'hFE); step(4);
    pulse(1, 0, 0, 0, 0);
    expect_int("R5", 1); expect_rd("R5", 8'hFE); settle;
    wr_port(8'hFF); step(4);
    expect_int("R5", 1); settle;

    // R10 change reaches synchronizer output one cycle before the clearing edge
    ext[5] = 0; step(2);
    pulse(1, 0, 1, 1, 0);
    expect_int("R10", 1); settle;
    pulse(1, 0, 0, 0, 0);
    expect_int("R10", 1); settle;
    ext[5] = 1; step(4); pulse(1, 0, 0, 0, 0);
    expect_int("R10", 0); settle;
    pulse(1, 0, 1, 1, 0);
    expect_int("R10", 1); settle;

    step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule